// File: doc/BRIEF.md
# Bit-Slip Word Realigner

This block sits in the parallel clock domain behind a serial-to-parallel converter. It takes raw words of `WORD_W` bits, each with a strobe, and moves the word boundary one bit at a time. Each slip delays the bit stream by one more bit. The output word is cut from the two most recent accepted words, starting at a bit offset that counts slips modulo `WORD_W`. Control logic raises a level request line to ask for a slip. Only the low-to-high transition of that line counts, so holding it high asks for just one slip.

After a slip, the valid flag stays low for a fixed settle window, which is two outputs by default. It comes back once words cut at the new boundary reach the output. When the converter is bypassed for single-rate or double-rate capture, the block passes through the one or two live bits. Slip requests are then ignored. A design with several lanes uses one instance per lane, so each lane slips on its own.

Top module: `bsr_bitslip_rx`

## Requirements
- R1: While `rst` is high at a clock edge, `slip_off` becomes 0, `out_vld` becomes 0, and both stored words become 0.
- R2: In word mode (`mode` = 2'b00), each slip step raises `slip_off` by one, modulo `WORD_W`. After `WORD_W - 1` it wraps to 0.
- R3: A slip step happens at an edge where `align_req` is sampled high and was sampled low at the previous edge (after reset it counts as low). Holding `align_req` high for any number of cycles gives one step. A single low cycle between two high cycles is enough for a second step.
- R4: In word mode, `out_word` is bits `[off+WORD_W-1 : off]` of the concatenation {previous word, current word}. Here `off` is the offset held before the edge, and bit 0 is the LSB of the current word. A word is accepted only at edges where `in_vld` is high. The previous word then takes the old current word.
- R5: In word mode, `out_vld` is 0 in the output registered at the slip edge. It is also 0 for the following `SETTLE_CYC - 1` edges. It then follows R6 again.
- R6: Outside the settle window, `out_vld` at each edge equals the `in_vld` sampled one edge earlier. `out_word` is registered at that same edge from the stored words, so the data latency is two edges.
- R7: In the bypass modes (`mode` other than 2'b00), `align_req` has no effect and `slip_off` holds its value. Returning to word mode while `align_req` is already high causes no step.
- R8: In mode 2'b01 (double rate), `out_word` carries bits [1:0] of the current word. In modes 2'b10 and 2'b11 (single rate), it carries bit [0]. All higher bits are 0. `out_vld` follows R6 with no settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 word, 01 double-rate bypass, 10/11 single-rate bypass |
| align_req | input | 1 | Level slip request; each rising edge slips one bit |
| in_word | input | WORD_W | Raw word from the deserializer |
| in_vld | input | 1 | Strobe marking `in_word` as a new word |
| out_word | output | WORD_W | Realigned word, or bypass bits |
| out_vld | output | 1 | Output word valid |
| slip_off | output | $clog2(WORD_W) | Current slip offset |

## Verification
Two events can land on the same edge: a slip can be sampled in the cycle a word arrives, or in a cycle with no word. The stored words and the offset then both change at that edge, and the next output must combine the old offset with the old pair. The bench provokes this with random request edges over a gappy word stream. It also re-triggers slips inside an open settle window. A queue-based model predicts the word, the flag and the offset on every clock, and any mismatch is reported. A second collision pairs a mode change with a request that is already high, and is judged by the offset staying put.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [1:0] {
      BSR_MODE_WORD = 2'b00,
      BSR_MODE_DDR  = 2'b01,
      BSR_MODE_SDR  = 2'b10,
      BSR_MODE_SDR1 = 2'b11
   } bsr_mode_e;

   function automatic logic bsr_is_word(input logic [1:0] m);
      return m == BSR_MODE_WORD;
   endfunction

   function automatic logic bsr_is_ddr(input logic [1:0] m);
      return m == BSR_MODE_DDR;
   endfunction

endpackage

// File: rtl/bsr_req_edge.sv
module bsr_req_edge (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic req,
   output logic rise
);
   logic req_q;

   always_ff @(posedge clk) begin
      if (rst) req_q <= 1'b0;
      else     req_q <= req;
   end

   // level history tracked in every mode so a mode switch never fakes an edge
   assign rise = en & req & ~req_q;
endmodule

// File: rtl/bsr_off_ctr.sv
module bsr_off_ctr #(
   parameter int WORD_W = 10,
   parameter int OFF_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [OFF_W-1:0] off
);
   localparam logic [OFF_W-1:0] LAST = OFF_W'(WORD_W - 1);

   always_ff @(posedge clk) begin
      if (rst)       off <= '0;
      else if (step) off <= (off == LAST) ? '0 : off + 1'b1;
   end
endmodule

// File: rtl/bsr_word_sel.sv
module bsr_word_sel
   import bsr_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int OFF_W  = 4
) (
   input  logic [WORD_W-1:0] prev_w,
   input  logic [WORD_W-1:0] cur_w,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        mode,
   output logic [WORD_W-1:0] word
);
   localparam int CAT_W = 2 * WORD_W;

   logic [CAT_W-1:0]  cat;
   logic [WORD_W-1:0] shifted;
   logic [WORD_W-1:0] bypassed;

   assign cat = {prev_w, cur_w};

   for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
      logic bit_s;
      always_comb begin
         bit_s = cur_w[gi];
         for (int k = 0; k < WORD_W; k++) begin
            if (off == OFF_W'(k)) bit_s = cat[gi + k];
         end
      end
      assign shifted[gi] = bit_s;

      if (gi == 0) begin : g_b0
         assign bypassed[gi] = cur_w[0];
      end else if (gi == 1) begin : g_b1
         assign bypassed[gi] = bsr_is_ddr(mode) & cur_w[1];
      end else begin : g_bz
         assign bypassed[gi] = 1'b0;
      end
   end

   assign word = bsr_is_word(mode) ? shifted : bypassed;
endmodule

// File: rtl/bsr_bitslip_rx.sv
module bsr_bitslip_rx
   import bsr_pkg::*;
#(
   parameter int WORD_W     = 10,
   parameter int SETTLE_CYC = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [1:0]                  mode,
   input  logic                        align_req,
   input  logic [WORD_W-1:0]           in_word,
   input  logic                        in_vld,
   output logic [WORD_W-1:0]           out_word,
   output logic                        out_vld,
   output logic [$clog2(WORD_W)-1:0]   slip_off
);
   localparam int OFF_W  = $clog2(WORD_W);
   localparam int HOLD_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   if (WORD_W < 3 || WORD_W > 10) begin : g_bad_width
      $error("bsr_bitslip_rx: WORD_W must lie in 3..10");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("bsr_bitslip_rx: SETTLE_CYC must be at least 1");
   end

   logic              word_mode;
   logic              rise;
   logic [OFF_W-1:0]  off;
   logic [WORD_W-1:0] prev_w, cur_w, sel_w;
   logic              cur_v;
   logic              settling;

   assign word_mode = bsr_is_word(mode);

   bsr_req_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .en   (word_mode),
      .req  (align_req),
      .rise (rise)
   );

   bsr_off_ctr #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .step (rise),
      .off  (off)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_w <= '0;
         cur_w  <= '0;
         cur_v  <= 1'b0;
      end else begin
         cur_v <= in_vld;
         if (in_vld) begin
            prev_w <= cur_w;
            cur_w  <= in_word;
         end
      end
   end

   if (SETTLE_CYC > 1) begin : g_hold
      logic [HOLD_W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (rst)                hold_q <= '0;
         else if (rise)          hold_q <= HOLD_W'(SETTLE_CYC - 1);
         else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
      end
      assign settling = rise | (hold_q != '0);
   end else begin : g_nohold
      assign settling = rise;
   end

   bsr_word_sel #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_sel (
      .prev_w (prev_w),
      .cur_w  (cur_w),
      .off    (off),
      .mode   (mode),
      .word   (sel_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_word <= '0;
         out_vld  <= 1'b0;
      end else begin
         out_word <= sel_w;
         out_vld  <= cur_v & (~word_mode | ~settling);
      end
   end

   assign slip_off = off;
endmodule

// File: rtl/bsr_bitslip_rx_chk.sv
module bsr_bitslip_rx_chk #(
   parameter int WORD_W = 10,
   parameter int OFF_W  = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       mode,
   input logic             align_req,
   input logic             in_vld,
   input logic [OFF_W-1:0] slip_off,
   input logic             out_vld
);
   logic a_last;
   logic word_rise;

   always_ff @(posedge clk) begin
      if (rst) a_last <= 1'b0;
      else     a_last <= align_req;
   end

   assign word_rise = (mode == 2'b00) && align_req && !a_last;

   AST_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
      int'(slip_off) < WORD_W); // R2

   AST_SLIP_STEP: assert property (@(posedge clk) disable iff (rst)
      word_rise |=> (int'(slip_off) == (int'($past(slip_off)) + 1) % WORD_W)); // R2

   AST_HELD_ONCE: assert property (@(posedge clk) disable iff (rst)
      (align_req && a_last) |=> $stable(slip_off)); // R3

   AST_BYPASS_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (mode != 2'b00) |=> $stable(slip_off)); // R7

   AST_SETTLE_LOW: assert property (@(posedge clk) disable iff (rst)
      word_rise |=> !out_vld); // R5

   AST_VLD_SOURCE: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> $past(in_vld, 2)); // R6
endmodule

bind bsr_bitslip_rx bsr_bitslip_rx_chk #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mode      (mode),
   .align_req (align_req),
   .in_vld    (in_vld),
   .slip_off  (slip_off),
   .out_vld   (out_vld)
);

// File: tb/tb_bsr_bitslip_rx.sv
`timescale 1ns/1ps
module tb_bsr_bitslip_rx;
   localparam int W      = 10;
   localparam int SETTLE = 2;
   localparam int OW     = $clog2(W);
   localparam int MASK   = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    mode;
   logic          align_req;
   logic [W-1:0]  in_word;
   logic          in_vld;
   logic [W-1:0]  out_word;
   logic          out_vld;
   logic [OW-1:0] slip_off;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   bsr_bitslip_rx #(.WORD_W(W), .SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .rst(rst), .mode(mode), .align_req(align_req),
      .in_word(in_word), .in_vld(in_vld),
      .out_word(out_word), .out_vld(out_vld), .slip_off(slip_off)
   );

   // behavioural reference: word history queue plus integer state
   int m_off, m_hold, m_alast, m_curv, e_word, e_vld;
   int hist[$];

   always @(posedge clk) begin
      int prevw, curw;
      bit rise;
      if (rst) begin
         m_off = 0; m_hold = 0; m_alast = 0; m_curv = 0;
         hist = {0, 0};
         e_word = 0; e_vld = 0;
      end else begin
         prevw = hist[0];
         curw  = hist[1];
         rise  = (mode == 2'b00) && align_req && (m_alast == 0);
         m_alast = align_req;
         case (mode)
            2'b00:   e_word = (((prevw << W) | curw) >> m_off) & MASK;
            2'b01:   e_word = curw & 3;
            default: e_word = curw & 1;
         endcase
         e_vld  = (m_curv != 0) && ((mode != 2'b00) || (!rise && m_hold == 0));
         m_hold = rise ? SETTLE - 1 : ((m_hold > 0) ? m_hold - 1 : 0);
         if (rise) m_off = (m_off + 1) % W;
         if (in_vld) begin
            hist.push_back(int'(in_word));
            void'(hist.pop_front());
         end
         m_curv = in_vld ? 1 : 0;
      end
   end

   task automatic expect_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      expect_eq("R4 or R8 out_word", int'(out_word), e_word);
      expect_eq("R5 or R6 out_vld",  int'(out_vld),  e_vld);
      expect_eq("R2 or R3 or R7 slip_off", int'(slip_off), m_off);
   endtask

   task automatic rand_word(input int gap_pct);
      in_vld  = (($urandom % 100) >= gap_pct);
      in_word = W'($urandom);
   endtask

   task automatic pulse_n(input int n);
      for (int p = 0; p < n; p++) begin
         align_req = 1'b1; rand_word(0); tick();
         align_req = 1'b0; rand_word(0); tick();
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int held_off;
      rst = 1'b1; mode = 2'b00; align_req = 1'b0; in_word = '0; in_vld = 1'b0;
      repeat (4) tick();
      // R1: reset state
      expect_eq("R1 slip_off in reset", int'(slip_off), 0);
      expect_eq("R1 out_vld in reset",  int'(out_vld), 0);
      rst = 1'b0;

      // R4 R6: plain stream with gaps, no slips
      for (int i = 0; i < 30; i++) begin rand_word(30); tick(); end

      // R2: W single pulses wrap the offset back to zero
      pulse_n(W);
      expect_eq("R2 wrap after WORD_W slips", int'(slip_off), 0);
      pulse_n(3);
      expect_eq("R2 three slips", int'(slip_off), 3);

      // R5 and R3: held request, settle window on a steady stream
      in_vld = 1'b1; in_word = W'($urandom);
      tick(); tick();
      align_req = 1'b1;
      in_word = W'($urandom); tick();
      expect_eq("R5 first settle output", int'(out_vld), 0);
      in_word = W'($urandom); tick();
      expect_eq("R5 second settle output", int'(out_vld), 0);
      in_word = W'($urandom); tick();
      expect_eq("R5 valid after settle", int'(out_vld), 1);
      for (int i = 0; i < 20; i++) begin rand_word(20); tick(); end
      expect_eq("R3 held high counts once", int'(slip_off), 4);
      align_req = 1'b0; tick();

      // R3: one low cycle between requests is enough
      align_req = 1'b1; tick();
      align_req = 1'b0; tick();
      align_req = 1'b1; tick();
      expect_eq("R3 minimum spacing", int'(slip_off), 6);
      align_req = 1'b0; tick();

      // R4 R5: random slips colliding with word arrivals and gaps
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 4) == 0) align_req = ~align_req;
         rand_word(35);
         tick();
      end
      align_req = 1'b0; tick();

      // R7 R8: bypass modes ignore requests and mask data
      for (int md = 1; md < 4; md++) begin
         mode = 2'(md);
         held_off = int'(slip_off);
         for (int i = 0; i < 12; i++) begin
            align_req = i[0];
            rand_word(25);
            tick();
         end
         expect_eq("R7 bypass holds offset", int'(slip_off), held_off);
         expect_eq("R8 bypass upper bits zero",
                   int'(out_word) >> ((md == 1) ? 2 : 1), 0);
      end

      // R7: entering word mode with the request already high
      align_req = 1'b1; tick();
      held_off = int'(slip_off);
      mode = 2'b00; tick(); tick();
      expect_eq("R7 no slip on mode return", int'(slip_off), held_off);
      align_req = 1'b0; tick();

      // mixed modes and slips
      for (int i = 0; i < 300; i++) begin
         if (($urandom % 16) == 0) mode = 2'($urandom);
         if (($urandom % 3) == 0) align_req = ~align_req;
         rand_word(30);
         tick();
      end

      done = 1;
      summary();
      $finish;
   end
endmodule